// File: doc/BRIEF.md
# Two-Stage Watchdog with Safe Clock-Source Fallback

This block supervises a clock generator's frequency configuration with two timers. A prescaled tick, one pulse per 290 ms period, advances both timers. Software restarts them by pulsing a trigger, or by toggling the watchdog enable. The shorter soft timer commits a pending CPU band change. The longer hard timer recovers from a configuration that has hung the platform. Either expiry drives an active-low reset output for a fixed number of clocks and raises a sticky status flag.

The block does not contain the PLLs. It outputs only codes: a source code for the CPU clock and one for the AGP/PCI clock, the effective band, CFS and AFS values, the two 10-bit N divider values and the latched hardware frequency-select pins. A band select that software writes stays pending until a soft expiry commits it. A hard expiry moves both clocks to their configured safe settings and turns off N programming. If relatching is enabled, a hard expiry also re-samples the hardware select pins.

Top module: `wdg_safe_fallback`

## Requirements
- R1: When `wd_en` is high and the hard limit L is not zero, the L-th `tick` pulse after a restart sets `hard_flag`. An earlier tick does not set it. After firing once, the hard timer stays idle until the next restart.
- R2: The soft timer counts only while both `wd_en` and `soft_en` are high. Its L-th tick after a restart sets `soft_flag`.
- R3: While `wd_en` is low, no tick sets a flag or pulls `rst_out_n` low.
- R4: Each expiry holds `rst_out_n` low for exactly RST_CYCLES (default 4) clocks, starting at the clock edge that sets the flag.
- R5: `cpu_band` takes the value of `band_sel` only at a soft expiry. A change of `band_sel` at any other time leaves `cpu_band` unchanged. Its reset value is 0.
- R6: A hard expiry clears both N-programming enables. When `relatch_en` is high, it also reloads `hw_fs_q` from `hw_fs`. The pin value is also captured while `rst_n` is low.
- R7: `cpu_src` is encoded as 0 = hardware FS, 1 = band/CFS, 2 = N programming, 3 = watchdog safe. The code is 3 when `hard_flag` and `cpu_safe` are both high. Otherwise it is 2 when the N enable is set, else 1 when `cpu_sw_sel` is high, else 0. With code 3, `cpu_band` and `cpu_cfs` show `wd_band` and `wd_cfs`.
- R8: `agp_src` is encoded as 0 = fixed 66/33, 1 = AFS table, 2 = N programming, 3 = watchdog safe. The code is 3 when `hard_flag` and `agp_safe` are both high, and `agp_afs` then shows `wd_afs`. Otherwise it is 2 when the N enable is set, else 1 when `agp_sel` is high, else 0.
- R9: A high-part write stages `n_data[1:0]` as bits 9:8 without changing the N output. A low-byte write loads {staged bits, `n_data`} into the N output. The reset value of both N outputs is 0x12A.
- R10: The status flags stay set until `kick`. A `kick` clears both flags and restarts both timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per 290 ms period |
| kick | input | 1 | Restart timers, clear flags |
| wd_en | input | 1 | Watchdog enable; a toggle restarts the timers |
| soft_en | input | 1 | Soft alarm enable |
| hard_limit | input | 8 | Hard timeout in ticks |
| soft_limit | input | 4 | Soft timeout in ticks |
| relatch_en | input | 1 | Re-sample hw_fs on hard expiry |
| hw_fs | input | 2 | Hardware frequency-select pins |
| cpu_sw_sel | input | 1 | CPU software band select |
| band_sel | input | 3 | Pending CPU band |
| cfs | input | 3 | CPU frequency select within band |
| cpu_safe | input | 1 | Use watchdog CPU setting after hard expiry |
| wd_band | input | 3 | Safe CPU band |
| wd_cfs | input | 3 | Safe CPU CFS |
| cpu_nen_wr | input | 1 | Write strobe, CPU N enable |
| cpu_nen_d | input | 1 | CPU N enable value |
| cpu_nhi_wr | input | 1 | Stage CPU N bits 9:8 |
| cpu_nlo_wr | input | 1 | Load CPU N |
| n_data | input | 8 | Shared N write data |
| agp_sel | input | 1 | AGP/PCI table select |
| afs | input | 3 | AGP/PCI table entry |
| agp_safe | input | 1 | Use watchdog AFS after hard expiry |
| wd_afs | input | 3 | Safe AGP/PCI AFS |
| agp_nen_wr | input | 1 | Write strobe, AGP N enable |
| agp_nen_d | input | 1 | AGP N enable value |
| agp_nhi_wr | input | 1 | Stage AGP N bits 9:8 |
| agp_nlo_wr | input | 1 | Load AGP N |
| rst_out_n | output | 1 | Active-low reset pulse |
| soft_flag | output | 1 | Soft expiry status |
| hard_flag | output | 1 | Hard expiry status |
| hw_fs_q | output | 2 | Latched hardware FS |
| cpu_src | output | 2 | CPU source code |
| cpu_band | output | 3 | Effective CPU band |
| cpu_cfs | output | 3 | Effective CPU CFS |
| cpu_n | output | 10 | Active CPU N |
| agp_src | output | 2 | AGP/PCI source code |
| agp_afs | output | 3 | Effective AFS |
| agp_n | output | 10 | Active AGP/PCI N |

## Verification
The assertions check four things on every cycle. The active band is held except at a soft expiry. Each expiry is followed by a low reset output and by cleared N enables. A flag, once set, stays set until a kick. Each timer fires at most once per arming. The bench scenarios cover what only a sequence of inputs can show: the exact tick count at which each timer fires, the length of the reset pulse, and the relatch of the hardware pins. They also show the source codes that result after the flag is cleared. The hidden N-enable state becomes visible at the ports that way.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {CPU_HWFS = 2'd0, CPU_BAND = 2'd1, CPU_NPROG = 2'd2, CPU_WDSAFE = 2'd3} cpu_src_e;
  typedef enum logic [1:0] {AGP_FIXED = 2'd0, AGP_TABLE = 2'd1, AGP_NPROG = 2'd2, AGP_WDSAFE = 2'd3} agp_src_e;

  function automatic cpu_src_e pick_cpu(logic hard, logic safe, logic nen, logic sw);
    if (hard && safe) return CPU_WDSAFE;
    if (nen) return CPU_NPROG;
    if (sw) return CPU_BAND;
    return CPU_HWFS;
  endfunction

  function automatic agp_src_e pick_agp(logic hard, logic safe, logic nen, logic sel);
    if (hard && safe) return AGP_WDSAFE;
    if (nen) return AGP_NPROG;
    if (sel) return AGP_TABLE;
    return AGP_FIXED;
  endfunction
endpackage

// File: rtl/wdg_stage.sv
module wdg_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic             done;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign fire = tick && run && !done && !restart && (limit != '0) &&
                (next_cnt == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (fire) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (tick && run && !done) begin
      cnt <= next_cnt[CNT_W-1:0];
    end
  end

  p_one_shot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rst_out_n
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (trig)         cnt <= CW'(RST_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign rst_out_n = (cnt == '0);
endmodule

// File: rtl/wdg_nreg.sv
module wdg_nreg #(
  parameter int          N_W     = 10,
  parameter logic [N_W-1:0] RST_VAL = 10'h12A
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hi_wr,
  input  logic [N_W-9:0] hi_d,
  input  logic           lo_wr,
  input  logic [7:0]     lo_d,
  output logic [N_W-1:0] nval
);
  logic [N_W-9:0] hi_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage <= RST_VAL[N_W-1:8];
      nval     <= RST_VAL;
    end else begin
      if (hi_wr) hi_stage <= hi_d;
      if (lo_wr) nval <= {(hi_wr ? hi_d : hi_stage), lo_d};
    end
  end

  p_n_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr |=> $stable(nval));
endmodule

// File: rtl/wdg_freq_sel.sv
module wdg_freq_sel
  import wdg_pkg::*;
#(
  parameter int BAND_W = 3,
  parameter int FS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_fire,
  input  logic              hard_fire,
  input  logic              hard_flag,
  input  logic              relatch_en,
  input  logic [FS_W-1:0]   hw_fs,
  input  logic              cpu_sw_sel,
  input  logic [BAND_W-1:0] band_sel,
  input  logic [BAND_W-1:0] cfs,
  input  logic              cpu_safe,
  input  logic [BAND_W-1:0] wd_band,
  input  logic [BAND_W-1:0] wd_cfs,
  input  logic              cpu_nen_wr,
  input  logic              cpu_nen_d,
  input  logic              agp_sel,
  input  logic [BAND_W-1:0] afs,
  input  logic              agp_safe,
  input  logic [BAND_W-1:0] wd_afs,
  input  logic              agp_nen_wr,
  input  logic              agp_nen_d,
  output logic [FS_W-1:0]   hw_fs_q,
  output logic [1:0]        cpu_src,
  output logic [BAND_W-1:0] cpu_band,
  output logic [BAND_W-1:0] cpu_cfs,
  output logic [1:0]        agp_src,
  output logic [BAND_W-1:0] agp_afs
);
  logic [BAND_W-1:0] active_band;
  logic              cpu_nen, agp_nen;
  cpu_src_e          csrc;
  agp_src_e          asrc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_band <= '0;
      hw_fs_q     <= hw_fs;
      cpu_nen     <= 1'b0;
      agp_nen     <= 1'b0;
    end else begin
      if (soft_fire) active_band <= band_sel;
      if (hard_fire) begin
        cpu_nen <= 1'b0;
        agp_nen <= 1'b0;
        if (relatch_en) hw_fs_q <= hw_fs;
      end else begin
        if (cpu_nen_wr) cpu_nen <= cpu_nen_d;
        if (agp_nen_wr) agp_nen <= agp_nen_d;
      end
    end
  end

  always_comb begin
    csrc     = pick_cpu(hard_flag, cpu_safe, cpu_nen, cpu_sw_sel);
    asrc     = pick_agp(hard_flag, agp_safe, agp_nen, agp_sel);
    cpu_src  = csrc;
    agp_src  = asrc;
    cpu_band = (csrc == CPU_WDSAFE) ? wd_band : active_band;
    cpu_cfs  = (csrc == CPU_WDSAFE) ? wd_cfs  : cfs;
    agp_afs  = (asrc == AGP_WDSAFE) ? wd_afs  : afs;
  end

  p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_fire |=> $stable(active_band));
  p_nen_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hard_fire |=> (!cpu_nen && !agp_nen));
endmodule

// File: rtl/wdg_safe_fallback.sv
module wdg_safe_fallback
  import wdg_pkg::*;
#(
  parameter int HARD_W     = 8,
  parameter int SOFT_W     = 4,
  parameter int N_W        = 10,
  parameter int BAND_W     = 3,
  parameter int FS_W       = 2,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              kick,
  input  logic              wd_en,
  input  logic              soft_en,
  input  logic [HARD_W-1:0] hard_limit,
  input  logic [SOFT_W-1:0] soft_limit,
  input  logic              relatch_en,
  input  logic [FS_W-1:0]   hw_fs,
  input  logic              cpu_sw_sel,
  input  logic [BAND_W-1:0] band_sel,
  input  logic [BAND_W-1:0] cfs,
  input  logic              cpu_safe,
  input  logic [BAND_W-1:0] wd_band,
  input  logic [BAND_W-1:0] wd_cfs,
  input  logic              cpu_nen_wr,
  input  logic              cpu_nen_d,
  input  logic              cpu_nhi_wr,
  input  logic              cpu_nlo_wr,
  input  logic [7:0]        n_data,
  input  logic              agp_sel,
  input  logic [BAND_W-1:0] afs,
  input  logic              agp_safe,
  input  logic [BAND_W-1:0] wd_afs,
  input  logic              agp_nen_wr,
  input  logic              agp_nen_d,
  input  logic              agp_nhi_wr,
  input  logic              agp_nlo_wr,
  output logic              rst_out_n,
  output logic              soft_flag,
  output logic              hard_flag,
  output logic [FS_W-1:0]   hw_fs_q,
  output logic [1:0]        cpu_src,
  output logic [BAND_W-1:0] cpu_band,
  output logic [BAND_W-1:0] cpu_cfs,
  output logic [N_W-1:0]    cpu_n,
  output logic [1:0]        agp_src,
  output logic [BAND_W-1:0] agp_afs,
  output logic [N_W-1:0]    agp_n
);
  localparam logic [N_W-1:0] N_RST = N_W'(10'h12A);

  logic wd_en_q, restart, soft_fire, hard_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_en_q <= 1'b0;
    else        wd_en_q <= wd_en;
  end
  assign restart = kick || (wd_en != wd_en_q);

  wdg_stage #(.CNT_W(SOFT_W)) u_soft (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(wd_en && soft_en),
    .tick(tick), .limit(soft_limit), .fire(soft_fire));

  wdg_stage #(.CNT_W(HARD_W)) u_hard (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(wd_en),
    .tick(tick), .limit(hard_limit), .fire(hard_fire));

  wdg_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(soft_fire || hard_fire), .rst_out_n(rst_out_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_flag <= 1'b0;
      hard_flag <= 1'b0;
    end else if (kick) begin
      soft_flag <= 1'b0;
      hard_flag <= 1'b0;
    end else begin
      if (soft_fire) soft_flag <= 1'b1;
      if (hard_fire) hard_flag <= 1'b1;
    end
  end

  wdg_freq_sel #(.BAND_W(BAND_W), .FS_W(FS_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .soft_fire(soft_fire), .hard_fire(hard_fire),
    .hard_flag(hard_flag), .relatch_en(relatch_en), .hw_fs(hw_fs),
    .cpu_sw_sel(cpu_sw_sel), .band_sel(band_sel), .cfs(cfs), .cpu_safe(cpu_safe),
    .wd_band(wd_band), .wd_cfs(wd_cfs), .cpu_nen_wr(cpu_nen_wr), .cpu_nen_d(cpu_nen_d),
    .agp_sel(agp_sel), .afs(afs), .agp_safe(agp_safe), .wd_afs(wd_afs),
    .agp_nen_wr(agp_nen_wr), .agp_nen_d(agp_nen_d), .hw_fs_q(hw_fs_q),
    .cpu_src(cpu_src), .cpu_band(cpu_band), .cpu_cfs(cpu_cfs),
    .agp_src(agp_src), .agp_afs(agp_afs));

  wdg_nreg #(.N_W(N_W), .RST_VAL(N_RST)) u_cpu_n (
    .clk(clk), .rst_n(rst_n), .hi_wr(cpu_nhi_wr), .hi_d(n_data[N_W-9:0]),
    .lo_wr(cpu_nlo_wr), .lo_d(n_data), .nval(cpu_n));

  wdg_nreg #(.N_W(N_W), .RST_VAL(N_RST)) u_agp_n (
    .clk(clk), .rst_n(rst_n), .hi_wr(agp_nhi_wr), .hi_d(n_data[N_W-9:0]),
    .lo_wr(agp_nlo_wr), .lo_d(n_data), .nval(agp_n));

  p_rst_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_fire || hard_fire) |=> !rst_out_n);
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !kick) |=> ($stable(soft_flag) && $stable(hard_flag)));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_flag && !kick) |=> soft_flag);
  p_hard_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_fire && cpu_safe && !kick) |=> (cpu_src == 2'd3));
endmodule

// File: tb/tb_wdg_safe_fallback.sv
module tb_wdg_safe_fallback;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, kick = 0, wd_en = 0, soft_en = 0, relatch_en = 0;
  logic [7:0] hard_limit = 8'd11, n_data = 8'd0;
  logic [3:0] soft_limit = 4'd2;
  logic [1:0] hw_fs = 2'b10;
  logic cpu_sw_sel = 0, cpu_safe = 0, agp_sel = 0, agp_safe = 0;
  logic [2:0] band_sel = 0, cfs = 0, wd_band = 0, wd_cfs = 0, afs = 0, wd_afs = 0;
  logic cpu_nen_wr = 0, cpu_nen_d = 0, cpu_nhi_wr = 0, cpu_nlo_wr = 0;
  logic agp_nen_wr = 0, agp_nen_d = 0, agp_nhi_wr = 0, agp_nlo_wr = 0;
  logic rst_out_n, soft_flag, hard_flag;
  logic [1:0] hw_fs_q, cpu_src, agp_src;
  logic [2:0] cpu_band, cpu_cfs, agp_afs;
  logic [9:0] cpu_n, agp_n;

  int errors = 0, checks = 0;
  logic finished = 0;

  always #10 clk = ~clk;

  wdg_safe_fallback dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_cpu(bit hard, bit safe, bit nen, bit sw);
    case ({hard & safe, nen, sw})
      3'b100, 3'b101, 3'b110, 3'b111: return 3;
      3'b010, 3'b011: return 2;
      3'b001: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_agp(bit hard, bit safe, bit nen, bit sel);
    return (hard && safe) ? 3 : (nen ? 2 : (sel ? 1 : 0));
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic pulse_tick();
    tick = 1; cyc(); tick = 0; #1;
  endtask

  task automatic pulse_kick();
    kick = 1; cyc(); kick = 0; #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lows;
    bit m_cnen, m_anen;
    logic [1:0] m_hi;
    logic [9:0] m_n;
    void'($urandom(32'd1234));
    repeat (3) cyc();
    rst_n = 1; cyc(); #1;
    // Reset state
    chk("R4 reset rst_out_n", rst_out_n, 1);
    chk("R10 reset soft_flag", soft_flag, 0);
    chk("R1 reset hard_flag", hard_flag, 0);
    chk("R9 reset cpu_n", cpu_n, 'h12A);
    chk("R9 reset agp_n", agp_n, 'h12A);
    chk("R6 reset hw_fs_q", hw_fs_q, 2);
    chk("R7 reset cpu_src", cpu_src, 0);
    chk("R5 reset cpu_band", cpu_band, 0);

    // R9: staging then load
    n_data = 8'h03; cpu_nhi_wr = 1; cyc(); cpu_nhi_wr = 0; #1;
    chk("R9 hi write no effect", cpu_n, 'h12A);
    n_data = 8'h55; cpu_nlo_wr = 1; cyc(); cpu_nlo_wr = 0; #1;
    chk("R9 lo write loads", cpu_n, 'h355);

    // R5: band pending
    band_sel = 3'd5; cpu_sw_sel = 1; cyc(); #1;
    chk("R5 band pending", cpu_band, 0);
    chk("R7 sw select", cpu_src, 1);

    // R3: disabled watchdog
    hard_limit = 8'd10; soft_limit = 4'd3; soft_en = 1;
    repeat (20) pulse_tick();
    chk("R3 idle soft", soft_flag, 0);
    chk("R3 idle hard", hard_flag, 0);
    chk("R3 idle rst", rst_out_n, 1);

    // R2: soft expiry on third tick
    wd_en = 1; cyc(); cyc(); #1;
    pulse_tick(); pulse_tick();
    chk("R2 soft early", soft_flag, 0);
    chk("R5 band held", cpu_band, 0);
    pulse_tick();
    chk("R2 soft expiry", soft_flag, 1);
    chk("R5 band committed", cpu_band, 5);
    chk("R4 rst low", rst_out_n, 0);
    lows = 1;
    while (!rst_out_n && lows < 50) begin cyc(); #1; if (!rst_out_n) lows++; end
    chk("R4 pulse length", lows, 4);
    repeat (5) cyc(); #1;
    chk("R10 sticky soft", soft_flag, 1);
    pulse_kick();
    chk("R10 kick clears", soft_flag, 0);

    // R1/R6/R7/R8: hard expiry
    soft_en = 0; band_sel = 3'd2;
    cpu_nen_d = 1; cpu_nen_wr = 1; agp_nen_d = 1; agp_nen_wr = 1; cyc();
    cpu_nen_wr = 0; agp_nen_wr = 0; #1;
    chk("R7 N enable", cpu_src, 2);
    chk("R8 N enable", agp_src, 2);
    cpu_safe = 1; agp_safe = 1; agp_sel = 1; wd_band = 3'd6; wd_cfs = 3'd4;
    wd_afs = 3'd7; afs = 3'd1; relatch_en = 1; hw_fs = 2'b01;
    pulse_kick();
    repeat (9) pulse_tick();
    chk("R1 hard early", hard_flag, 0);
    chk("R6 no relatch early", hw_fs_q, 2);
    pulse_tick();
    chk("R1 hard expiry", hard_flag, 1);
    chk("R4 rst low hard", rst_out_n, 0);
    chk("R7 safe cpu src", cpu_src, 3);
    chk("R7 safe band", cpu_band, 6);
    chk("R7 safe cfs", cpu_cfs, 4);
    chk("R8 safe agp src", agp_src, 3);
    chk("R8 safe afs", agp_afs, 7);
    chk("R6 relatch", hw_fs_q, 1);
    chk("R5 band not from hard", band_sel == 3'd2 ? 1 : 0, 1);
    repeat (15) pulse_tick();
    chk("R1 one shot", rst_out_n, 1);
    pulse_kick();
    chk("R10 hard cleared", hard_flag, 0);
    chk("R6 cpu nen cleared", cpu_src, 1);
    chk("R6 agp nen cleared", agp_src, 1);
    chk("R5 band kept", cpu_band, 5);
    chk("R8 table afs", agp_afs, 1);

    // Random: selection and N programming with timers disabled
    wd_en = 0; cyc(); cyc(); #1;
    m_cnen = 0; m_anen = 0; m_hi = 2'b01; m_n = 'h12A;
    for (int i = 0; i < 80; i++) begin
      bit wr_c, wr_a, hi, lo;
      wr_c = $urandom_range(0, 1); wr_a = $urandom_range(0, 1);
      cpu_nen_d = $urandom_range(0, 1); agp_nen_d = $urandom_range(0, 1);
      cpu_sw_sel = $urandom_range(0, 1); agp_sel = $urandom_range(0, 1);
      cpu_safe = $urandom_range(0, 1); agp_safe = $urandom_range(0, 1);
      hi = $urandom_range(0, 1); lo = $urandom_range(0, 1);
      n_data = 8'($urandom);
      cpu_nen_wr = wr_c; agp_nen_wr = wr_a; agp_nhi_wr = hi; agp_nlo_wr = lo;
      if (wr_c) m_cnen = cpu_nen_d;
      if (wr_a) m_anen = agp_nen_d;
      if (hi) m_hi = n_data[1:0];
      if (lo) m_n = {m_hi, n_data};
      cyc();
      cpu_nen_wr = 0; agp_nen_wr = 0; agp_nhi_wr = 0; agp_nlo_wr = 0; #1;
      chk("R7 random cpu_src", cpu_src, ref_cpu(0, cpu_safe, m_cnen, cpu_sw_sel));
      chk("R8 random agp_src", agp_src, ref_agp(0, agp_safe, m_anen, agp_sel));
      chk("R9 random agp_n", agp_n, m_n);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule